// File: doc/BRIEF.md
# CAN Acceptance Filter Router

This block sits behind a CAN receiver. It takes each frame that has already passed the receiver's error checks and decides which of two receive buffers stores that frame, or whether the frame is dropped. A frame is presented as one strobe. The strobe carries the identifier, the extended-format flag, the remote flag and the first two data bytes. The block compares a match key built from the frame against six host-programmed filters. Each filter is qualified by the mask of its buffer's group. The result is registered: one cycle after the strobe, the block reports whether the frame was accepted, which buffer takes it and which filter produced the hit.

The filters are split unevenly. The low group of filters serves the first buffer and the remaining filters serve the second. The first buffer has priority. Each buffer holds a full flag that stays set until the host clears it. While a buffer is full, a frame steered to it is dropped and an overflow pulse is raised for that buffer. Each buffer also drives a dedicated indication pin. The host can switch that pin to act as a general-purpose output.

Top module: `can_accept_router`

## Requirements
- R1: After reset both buffers are free, and `acc_valid`, `drop_ovf`, `buf_full` and `acc_filt` are all zero.
- R2: A mask bit of 0 makes that key bit a don't-care. A mask bit of 1 requires the key bit to equal the filter bit.
- R3: A filter can only hit when its format bit (`flt_ext[i]`, 1 = extended) equals the frame's `frm_ext`. An extended frame's key is its full 29-bit identifier.
- R4: For a standard data frame the key is built as follows. Bits 10:0 hold the identifier. Bits 18:11 hold the first data byte (`frm_data[7:0]`). Bits 26:19 hold the second data byte (`frm_data[15:8]`). Bits 28:27 are zero. For a standard remote frame only key bits 10:0 are compared.
- R5: Filters 0 and 1, under mask 0 (`msk_id[28:0]`), route to buffer 0. Filters 2 to 5, under mask 1 (`msk_id[57:29]`), route to buffer 1. `acc_buf` is 0 for buffer 0 and 1 for buffer 1.
- R6: When both groups hit and buffer 0 is free, the frame goes to buffer 0. `acc_filt` reports the lowest-numbered hitting filter of the group that wins.
- R7: When group 0 hits and buffer 0 is full, the frame is dropped and `drop_ovf[0]` pulses. This holds even if group 1 also hits: the frame is never moved to buffer 1.
- R8: When only group 1 hits and buffer 1 is full, the frame is dropped and `drop_ovf[1]` pulses.
- R9: A frame that hits no filter is not accepted, raises no overflow and changes no full flag.
- R10: Results appear in the cycle after the clock edge that samples `frm_valid` high, and last one cycle. Frame inputs presented while `frm_valid` is low have no effect.
- R11: A buffer's full flag is set by an accept into that buffer and stays set until `clr_full` for that buffer. If a clear and an accept into the same free buffer occur in one cycle, the flag ends up set.
- R12: `bf_pin[b]` equals `pin_gp_val[b]` when `pin_gp_mode[b]` is 1, and equals `buf_full[b]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Error-free frame present this cycle |
| frm_id | input | 29 | Frame identifier; a standard identifier sits in bits 10:0 |
| frm_ext | input | 1 | 1 = extended-format frame |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_data | input | 16 | First data byte in 7:0, second in 15:8 |
| flt_id | input | 174 | Six 29-bit filter values, filter i at bits 29*i+28:29*i |
| flt_ext | input | 6 | Per-filter format bit |
| msk_id | input | 58 | Mask 0 in 28:0, mask 1 in 57:29 |
| clr_full | input | 2 | Host clear of each buffer's full flag |
| pin_gp_mode | input | 2 | 1 = indication pin acts as general-purpose output |
| pin_gp_val | input | 2 | General-purpose output value |
| acc_valid | output | 1 | Frame accepted (one-cycle pulse) |
| acc_buf | output | 1 | Target buffer of the accepted frame |
| acc_filt | output | 3 | Index of the filter that hit |
| drop_ovf | output | 2 | Per-buffer overflow pulse on a dropped frame |
| buf_full | output | 2 | Per-buffer full flag |
| bf_pin | output | 2 | Per-buffer indication pin |

## Verification
The assertions assume `clr_full` is the only way a full flag falls. They also assume that `acc_valid` is never seen without a sampled `frm_valid` one edge earlier. For this reason the bench only changes inputs on the falling edge, holds `frm_valid` for exactly one cycle per frame and releases it before sampling results. To keep hits frequent, the random frames are often paired with a filter rewritten to that frame's own key. Masks are random, so hits, misses, format mismatches and both-group hits all occur. Full flags build up naturally because clears are issued only on a random fraction of frames.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
   localparam int unsigned ID_W   = 29;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned N_BUF  = 2;

   typedef enum logic [0:0] {
      RXB_LOW  = 1'b0,
      RXB_HIGH = 1'b1
   } rxbuf_e;
endpackage

// File: rtl/acf_key_build.sv
module acf_key_build
   import can_acf_pkg::*;
#(
   parameter int unsigned STD_W    = 11,
   parameter int unsigned DB_BYTES = 2
) (
   input  logic [ID_W-1:0]            id,
   input  logic                       ext,
   input  logic                       rtr,
   input  logic [DB_BYTES*BYTE_W-1:0] data,
   output logic [ID_W-1:0]            key,
   output logic [ID_W-1:0]            care
);
   localparam int unsigned STD_KEY_W = STD_W + DB_BYTES*BYTE_W;

   if (STD_KEY_W > ID_W) begin : g_bad_width
      $error("standard key wider than identifier space");
   end

   logic [ID_W-1:0] std_key;
   logic [ID_W-1:0] rmt_care;

   assign std_key[STD_W-1:0] = id[STD_W-1:0];
   for (genvar b = 0; b < DB_BYTES; b++) begin : g_dbyte
      assign std_key[STD_W + b*BYTE_W +: BYTE_W] = data[b*BYTE_W +: BYTE_W];
   end
   if (STD_KEY_W < ID_W) begin : g_pad
      assign std_key[ID_W-1:STD_KEY_W] = '0;
   end

   assign rmt_care = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

   always_comb begin
      if (ext) begin
         key  = id;
         care = '1;
      end else if (rtr) begin
         key  = std_key;
         care = rmt_care;
      end else begin
         key  = std_key;
         care = '1;
      end
   end
endmodule

// File: rtl/acf_match_bank.sv
module acf_match_bank
   import can_acf_pkg::*;
#(
   parameter int unsigned N_FILT = 6,
   parameter int unsigned N_GRP0 = 2
) (
   input  logic [ID_W-1:0]        key,
   input  logic [ID_W-1:0]        care,
   input  logic                   ext,
   input  logic [N_FILT*ID_W-1:0] flt_id,
   input  logic [N_FILT-1:0]      flt_ext,
   input  logic [N_BUF*ID_W-1:0]  msk_id,
   output logic [N_FILT-1:0]      hit
);
   if (N_GRP0 < 1 || N_GRP0 >= N_FILT) begin : g_bad_split
      $error("filter split must leave each group non-empty");
   end

   for (genvar i = 0; i < N_FILT; i++) begin : g_flt
      localparam int unsigned GRP = (i < N_GRP0) ? 0 : 1;
      logic [ID_W-1:0] diff;
      assign diff   = (key ^ flt_id[i*ID_W +: ID_W]) & msk_id[GRP*ID_W +: ID_W] & care;
      assign hit[i] = (flt_ext[i] == ext) && (diff == '0);
   end
endmodule

// File: rtl/acf_route.sv
module acf_route
   import can_acf_pkg::*;
#(
   parameter int unsigned N_FILT = 6,
   parameter int unsigned N_GRP0 = 2,
   parameter int unsigned FIDX_W = 3
) (
   input  logic [N_FILT-1:0] hit,
   input  logic [N_BUF-1:0]  full,
   output logic              go_valid,
   output rxbuf_e            go_buf,
   output logic [FIDX_W-1:0] go_filt,
   output logic [N_BUF-1:0]  go_ovf
);
   logic              g0_any, g1_any;
   logic [FIDX_W-1:0] g0_idx, g1_idx;

   always_comb begin
      g0_any = 1'b0;
      g0_idx = '0;
      for (int i = N_GRP0 - 1; i >= 0; i--) begin
         if (hit[i]) begin
            g0_any = 1'b1;
            g0_idx = FIDX_W'(i);
         end
      end
      g1_any = 1'b0;
      g1_idx = '0;
      for (int i = N_FILT - 1; i >= int'(N_GRP0); i--) begin
         if (hit[i]) begin
            g1_any = 1'b1;
            g1_idx = FIDX_W'(i);
         end
      end
   end

   always_comb begin
      go_valid = 1'b0;
      go_buf   = RXB_LOW;
      go_filt  = '0;
      go_ovf   = '0;
      if (g0_any) begin
         if (!full[0]) begin
            go_valid = 1'b1;
            go_filt  = g0_idx;
         end else begin
            go_ovf[0] = 1'b1;
         end
      end else if (g1_any) begin
         if (!full[1]) begin
            go_valid = 1'b1;
            go_buf   = RXB_HIGH;
            go_filt  = g1_idx;
         end else begin
            go_ovf[1] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/acf_buf_state.sv
module acf_buf_state
   import can_acf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_BUF-1:0] set,
   input  logic [N_BUF-1:0] clr,
   output logic [N_BUF-1:0] full
);
   for (genvar b = 0; b < N_BUF; b++) begin : g_buf
      always_ff @(posedge clk) begin
         if (!rst_n) full[b] <= 1'b0;
         else        full[b] <= set[b] | (full[b] & ~clr[b]);
      end

      a_r11_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
         full[b] && !clr[b] |=> full[b]);
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[b] |=> full[b]);
      a_r11_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
         clr[b] && !set[b] |=> !full[b]);
   end
endmodule

// File: rtl/can_accept_router.sv
module can_accept_router
   import can_acf_pkg::*;
#(
   parameter int unsigned N_FILT   = 6,
   parameter int unsigned N_GRP0   = 2,
   parameter int unsigned STD_W    = 11,
   parameter int unsigned DB_BYTES = 2,
   localparam int unsigned FIDX_W  = (N_FILT > 1) ? $clog2(N_FILT) : 1,
   localparam int unsigned DATA_W  = DB_BYTES*BYTE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_valid,
   input  logic [ID_W-1:0]        frm_id,
   input  logic                   frm_ext,
   input  logic                   frm_rtr,
   input  logic [DATA_W-1:0]      frm_data,
   input  logic [N_FILT*ID_W-1:0] flt_id,
   input  logic [N_FILT-1:0]      flt_ext,
   input  logic [N_BUF*ID_W-1:0]  msk_id,
   input  logic [N_BUF-1:0]       clr_full,
   input  logic [N_BUF-1:0]       pin_gp_mode,
   input  logic [N_BUF-1:0]       pin_gp_val,
   output logic                   acc_valid,
   output logic                   acc_buf,
   output logic [FIDX_W-1:0]      acc_filt,
   output logic [N_BUF-1:0]       drop_ovf,
   output logic [N_BUF-1:0]       buf_full,
   output logic [N_BUF-1:0]       bf_pin
);
   logic [ID_W-1:0]   key, care;
   logic [N_FILT-1:0] hit;
   logic              go_valid;
   rxbuf_e            go_buf;
   logic [FIDX_W-1:0] go_filt;
   logic [N_BUF-1:0]  go_ovf;
   logic [N_BUF-1:0]  set_full;

   acf_key_build #(.STD_W(STD_W), .DB_BYTES(DB_BYTES)) u_key (
      .id(frm_id), .ext(frm_ext), .rtr(frm_rtr), .data(frm_data),
      .key(key), .care(care));

   acf_match_bank #(.N_FILT(N_FILT), .N_GRP0(N_GRP0)) u_match (
      .key(key), .care(care), .ext(frm_ext), .flt_id(flt_id),
      .flt_ext(flt_ext), .msk_id(msk_id), .hit(hit));

   acf_route #(.N_FILT(N_FILT), .N_GRP0(N_GRP0), .FIDX_W(FIDX_W)) u_route (
      .hit(hit), .full(buf_full), .go_valid(go_valid), .go_buf(go_buf),
      .go_filt(go_filt), .go_ovf(go_ovf));

   assign set_full[0] = frm_valid && go_valid && (go_buf == RXB_LOW);
   assign set_full[1] = frm_valid && go_valid && (go_buf == RXB_HIGH);

   acf_buf_state u_state (
      .clk(clk), .rst_n(rst_n), .set(set_full), .clr(clr_full), .full(buf_full));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_buf   <= 1'b0;
         acc_filt  <= '0;
         drop_ovf  <= '0;
      end else begin
         acc_valid <= frm_valid && go_valid;
         acc_buf   <= frm_valid && go_valid && (go_buf == RXB_HIGH);
         acc_filt  <= (frm_valid && go_valid) ? go_filt : '0;
         drop_ovf  <= frm_valid ? go_ovf : '0;
      end
   end

   for (genvar b = 0; b < N_BUF; b++) begin : g_pin
      assign bf_pin[b] = pin_gp_mode[b] ? pin_gp_val[b] : buf_full[b];
   end

   a_r10_accept_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> $past(frm_valid));
   a_r10_ovf_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (|drop_ovf) |-> $past(frm_valid));
   a_r5_low_group: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_buf |-> int'(acc_filt) < int'(N_GRP0));
   a_r5_high_group: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_buf |-> int'(acc_filt) >= int'(N_GRP0) && int'(acc_filt) < int'(N_FILT));
   a_r7_drop_excludes_accept: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> drop_ovf == '0);
   a_r7_single_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drop_ovf));
   a_r7_ovf0_means_full: assert property (@(posedge clk) disable iff (!rst_n)
      drop_ovf[0] |-> $past(buf_full[0]));
   a_r8_ovf1_means_full: assert property (@(posedge clk) disable iff (!rst_n)
      drop_ovf[1] |-> $past(buf_full[1]));
   a_r11_low_target_free: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_buf |-> !$past(buf_full[0]) && buf_full[0]);
   a_r11_high_target_free: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_buf |-> !$past(buf_full[1]) && buf_full[1]);
endmodule

// File: tb/can_accept_router_test.sv
module can_accept_router_test;
   localparam int NF = 6;
   localparam int IW = 29;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frm_valid = 1'b0;
   logic [IW-1:0]     frm_id = '0;
   logic              frm_ext = 1'b0;
   logic              frm_rtr = 1'b0;
   logic [15:0]       frm_data = '0;
   logic [NF*IW-1:0]  flt_id;
   logic [NF-1:0]     flt_ext = '0;
   logic [2*IW-1:0]   msk_id;
   logic [1:0]        clr_full = '0;
   logic [1:0]        pin_gp_mode = '0;
   logic [1:0]        pin_gp_val = '0;
   logic              acc_valid, acc_buf;
   logic [2:0]        acc_filt;
   logic [1:0]        drop_ovf, buf_full, bf_pin;

   logic [IW-1:0] f_id [NF];
   logic [IW-1:0] mk [2];
   logic [1:0]    mf = '0;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NF; i++) flt_id[i*IW +: IW] = f_id[i];
      msk_id = {mk[1], mk[0]};
   end

   can_accept_router uut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
      .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_data(frm_data),
      .flt_id(flt_id), .flt_ext(flt_ext), .msk_id(msk_id), .clr_full(clr_full),
      .pin_gp_mode(pin_gp_mode), .pin_gp_val(pin_gp_val), .acc_valid(acc_valid),
      .acc_buf(acc_buf), .acc_filt(acc_filt), .drop_ovf(drop_ovf),
      .buf_full(buf_full), .bf_pin(bf_pin));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // key and care per R3/R4
   function automatic logic [IW-1:0] mkey(logic [IW-1:0] id, logic ext, logic rtr, logic [15:0] d);
      if (ext) return id;
      if (rtr) return {18'b0, id[10:0]};
      return {2'b00, d[15:8], d[7:0], id[10:0]};
   endfunction

   function automatic logic [IW-1:0] mcare(logic ext, logic rtr);
      if (!ext && rtr) return {18'b0, 11'h7FF};
      return '1;
   endfunction

   function automatic bit fhit(int i, logic [IW-1:0] id, logic ext, logic rtr, logic [15:0] d);
      logic [IW-1:0] m;
      m = (i < 2) ? mk[0] : mk[1];
      return (flt_ext[i] == ext) && (((mkey(id, ext, rtr, d) ^ f_id[i]) & m & mcare(ext, rtr)) == '0);
   endfunction

   task automatic check_pins(input string tag);
      for (int b = 0; b < 2; b++) begin
         logic e;
         e = pin_gp_mode[b] ? pin_gp_val[b] : mf[b];
         check(bf_pin[b] == e, {tag, " R12 pin"}, bf_pin[b], e);
      end
   endtask

   task automatic send(input logic [IW-1:0] id, input logic ext, input logic rtr,
                       input logic [15:0] d, input logic vld, input logic [1:0] clr,
                       input string tag);
      int g0, g1;
      bit ev, eb;
      int ef;
      logic [1:0] eo, set;
      g0 = -1; g1 = -1;
      for (int i = 1; i >= 0; i--) if (fhit(i, id, ext, rtr, d)) g0 = i;
      for (int i = NF-1; i >= 2; i--) if (fhit(i, id, ext, rtr, d)) g1 = i;
      ev = 0; eb = 0; ef = 0; eo = 2'b00;
      if (vld) begin
         if (g0 >= 0) begin
            if (!mf[0]) begin ev = 1; ef = g0; end else eo[0] = 1'b1;
         end else if (g1 >= 0) begin
            if (!mf[1]) begin ev = 1; eb = 1; ef = g1; end else eo[1] = 1'b1;
         end
      end
      set = {ev & eb, ev & ~eb};
      frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_data = d;
      frm_valid = vld; clr_full = clr;
      @(posedge clk);
      @(negedge clk);
      frm_valid = 1'b0; clr_full = 2'b00;
      mf = set | (mf & ~clr);
      check(acc_valid == ev, {tag, " acc_valid"}, acc_valid, ev);
      if (ev) begin
         check(acc_buf == eb, {tag, " acc_buf"}, acc_buf, eb);
         check(int'(acc_filt) == ef, {tag, " acc_filt"}, acc_filt, ef);
      end
      check(drop_ovf == eo, {tag, " drop_ovf"}, drop_ovf, eo);
      check(buf_full == mf, {tag, " R11 buf_full"}, buf_full, mf);
      check_pins(tag);
   endtask

   task automatic clear_all();
      send('0, 1'b0, 1'b0, '0, 1'b0, 2'b11, "R11 clear");
   endtask

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [IW-1:0] id;
      logic [15:0] d;
      logic ext, rtr;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NF; i++) f_id[i] = 29'h1FFF_FFFF;
      flt_ext = 6'b111111;
      mk[0] = '1; mk[1] = '1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(acc_valid == 0, "R1 acc_valid", acc_valid, 0);
      check(drop_ovf == 0, "R1 drop_ovf", drop_ovf, 0);
      check(buf_full == 0, "R1 buf_full", buf_full, 0);
      check(acc_filt == 0, "R1 acc_filt", acc_filt, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: masked-out bit ignored, masked-in bit compared
      flt_ext = 6'b000000;
      f_id[1] = {2'b0, 8'h34, 8'h12, 11'h155};
      mk[0] = ~29'h1;
      send({18'b0, 11'h154}, 1'b0, 1'b0, 16'h3412, 1'b1, 2'b00, "R2 dontcare hit");
      clear_all();
      mk[0] = '1;
      send({18'b0, 11'h154}, 1'b0, 1'b0, 16'h3412, 1'b1, 2'b00, "R2 compared miss");
      // R4: data byte mismatch, remote ignores data
      send({18'b0, 11'h155}, 1'b0, 1'b0, 16'h3413, 1'b1, 2'b00, "R4 data miss");
      send({18'b0, 11'h155}, 1'b0, 1'b1, 16'h0000, 1'b1, 2'b00, "R4 remote hit");
      clear_all();
      // R3: format mismatch
      send({18'b0, 11'h155}, 1'b1, 1'b0, 16'h3412, 1'b1, 2'b00, "R3 format miss");
      // R5/R6: both groups hit, buffer 0 wins with lowest index
      flt_ext = 6'b111111;
      for (int i = 0; i < NF; i++) f_id[i] = 29'h0ABC_DEF1;
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R6 both groups");
      // R7: buffer 0 full, group 1 also hits -> dropped
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R7 drop b0");
      // R5: only group 1 hits -> buffer 1, filter 3
      f_id[0] = 0; f_id[1] = 0; f_id[2] = 0;
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R5 to b1");
      // R8: buffer 1 full
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R8 drop b1");
      // R9: no hit
      send(29'h1555_5555, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R9 no hit");
      // R11: clear plus accept same cycle, set wins
      send('0, 1'b0, 1'b0, '0, 1'b0, 2'b10, "R11 clear b1");
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b10, "R11 set wins");
      clear_all();
      // R10: inputs without frm_valid ignored
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b0, 2'b00, "R10 no valid");
      // R12: general purpose pin mode
      pin_gp_mode = 2'b11; pin_gp_val = 2'b10;
      send(29'h0ABC_DEF1, 1'b1, 1'b0, 16'h0, 1'b1, 2'b00, "R12 gp mode");
      pin_gp_mode = 2'b00;
      clear_all();

      // constrained random
      for (int n = 0; n < 600; n++) begin
         id  = 29'($urandom);
         ext = 1'($urandom);
         rtr = ($urandom % 4) == 0;
         d   = 16'($urandom);
         if (!ext) id[28:11] = 18'($urandom);
         if (($urandom % 2) == 0) begin
            int k;
            k = int'($urandom % NF);
            f_id[k] = mkey(id, ext, rtr, d);
            flt_ext[k] = ext;
         end
         if (($urandom % 8) == 0) mk[$urandom % 2] = 29'($urandom) | 29'($urandom);
         if (($urandom % 16) == 0) begin
            pin_gp_mode = 2'($urandom); pin_gp_val = 2'($urandom);
         end
         send(id, ext, rtr, d, ($urandom % 8) != 0, (($urandom % 4) == 0) ? 2'($urandom) : 2'b00,
              "R2 R3 R4 R5 R6 R7 R8 R9 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule